// File: doc/BRIEF.md
# Format-Selected Frame Word Writer

This block runs in the system clock domain and turns 96-bit frames into 32-bit memory writes. When a frame-valid pulse arrives while the sequencer is idle, the block takes either one or two 32-bit words from the frame. The number of words depends on a format setting that software writes ahead of time. The bits the format does not select are dropped. Each word goes out on a RAM write port at the next address in sequence.

Each frame is accepted in one clock edge, so the frame bus may change right after the valid pulse. The format setting is sampled only when a frame is accepted, which means a frame in progress cannot be split across two formats. A valid pulse that lands while the second word of a frame is still being written cannot be served. That frame is discarded and a sticky flag records it. A running count of the words written is also provided.

Top module: `frame_word_writer`

## Requirements
- R1: After reset, no write is issued, `word_count_o` is 0 and `dropped_o` is 0.
- R2: With format value 0, an accepted frame produces exactly one write, one cycle after the valid edge. Its data is frame bits [95:64].
- R3: With format value 1, an accepted frame produces two writes on consecutive cycles. The first carries bits [95:64] and the second carries bits [63:32]. Bits [31:0] are never written.
- R4: The second word of a two-word frame is taken from the frame value present at the valid edge. Later changes on `frame_i` do not affect it.
- R5: The first write after reset goes to address 0. Each further write uses the previous address plus one, and address 1023 is followed by address 0.
- R6: A format write affects only frames accepted after the edge that stores it. A frame whose valid pulse falls on the same edge as the write uses the old format. A write made during a two-word frame leaves that frame's second word in place.
- R7: A valid pulse during the cycle in which a second word is issued produces no write for that frame. It sets `dropped_o`, which stays at 1 until reset.
- R8: `word_count_o` rises by one for every word written. The new value appears in the same cycle as that word's write.
- R9: With format 0, valid pulses on consecutive cycles are all accepted, and each produces one write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 96 | Frame data, sampled on a valid edge |
| frame_valid_i | input | 1 | Single-cycle frame valid pulse |
| fmt_we_i | input | 1 | Format register write strobe |
| fmt_i | input | 1 | Format value: 0 = one word, 1 = two words |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 10 | RAM write address |
| ram_data_o | output | 32 | RAM write data |
| word_count_o | output | 16 | Number of words written since reset (wraps) |
| dropped_o | output | 1 | Sticky flag: a frame arrived while a second word was pending |

## Verification
Two things can fall in the same cycle: acceptance of a new frame and issue of a pending second word. A format write can also coincide with either of them. The bench provokes these cases by pulsing valid in the cycle right after a two-word frame, and by placing format writes on the same edge as a valid pulse and inside a second-word cycle. Expected writes, addresses, counts and the drop flag come from a cycle-level model built from the requirements. That model is compared against the outputs at every cycle.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
  typedef enum logic {ST_WAIT = 1'b0, ST_SECOND = 1'b1} seq_state_e;
  typedef enum logic {FMT_ONE = 1'b0, FMT_TWO = 1'b1} fmt_e;
endpackage

// File: rtl/fwr_fmt_reg.sv
module fwr_fmt_reg
  import fwr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  fmt_e fmt_i,
  output fmt_e fmt_o
);
  fmt_e fmt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fmt_q <= FMT_ONE;
    else if (we_i) fmt_q <= fmt_i;
  end

  assign fmt_o = fmt_q;
endmodule

// File: rtl/fwr_seq.sv
module fwr_seq
  import fwr_pkg::*;
#(
  parameter int FRAME_W = 96,
  parameter int WORD_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               valid_i,
  input  fmt_e               fmt_i,
  output logic               adv_o,
  output logic               we_o,
  output logic [WORD_W-1:0]  data_o,
  output logic               drop_o
);
  localparam int HI_LSB = FRAME_W - WORD_W;
  localparam int LO_LSB = FRAME_W - 2 * WORD_W;

  seq_state_e        state_q;
  logic [WORD_W-1:0] hold_q;
  logic              accept, second;

  assign accept = (state_q == ST_WAIT) && valid_i;
  assign second = (state_q == ST_SECOND);
  assign adv_o  = accept | second;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      hold_q  <= '0;
      we_o    <= 1'b0;
      data_o  <= '0;
      drop_o  <= 1'b0;
    end else begin
      we_o <= adv_o;
      if (second) begin
        data_o  <= hold_q;
        state_q <= ST_WAIT;
        if (valid_i) drop_o <= 1'b1;
      end else if (accept) begin
        data_o <= frame_i[HI_LSB +: WORD_W];
        if (fmt_i == FMT_TWO) begin
          hold_q  <= frame_i[LO_LSB +: WORD_W];
          state_q <= ST_SECOND;
        end
      end
    end
  end

  p_second_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SECOND) |=> we_o);
  p_busy_valid_drops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SECOND && valid_i) |=> drop_o);
  p_drop_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> drop_o);
  p_one_word_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && fmt_i == FMT_ONE) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/fwr_addr.sv
module fwr_addr #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [ADDR_W-1:0] next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q <= '0;
      addr_o <= '0;
      cnt_o  <= '0;
    end else if (adv_i) begin
      addr_o <= next_q;
      next_q <= next_q + ADDR_W'(1);
      cnt_o  <= cnt_o + CNT_W'(1);
    end
  end

  p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && next_q == '1) |=> (next_q == '0));
endmodule

// File: rtl/frame_word_writer.sv
module frame_word_writer
  import fwr_pkg::*;
#(
  parameter int FRAME_W = 96,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 10,
  parameter int CNT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               frame_valid_i,
  input  logic               fmt_we_i,
  input  logic               fmt_i,
  output logic               ram_we_o,
  output logic [ADDR_W-1:0]  ram_addr_o,
  output logic [WORD_W-1:0]  ram_data_o,
  output logic [CNT_W-1:0]   word_count_o,
  output logic               dropped_o
);
  fmt_e fmt_cur;
  logic adv;

  fwr_fmt_reg u_fmt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (fmt_we_i),
    .fmt_i  (fmt_e'(fmt_i)),
    .fmt_o  (fmt_cur)
  );

  fwr_seq #(.FRAME_W(FRAME_W), .WORD_W(WORD_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .valid_i (frame_valid_i),
    .fmt_i   (fmt_cur),
    .adv_o   (adv),
    .we_o    (ram_we_o),
    .data_o  (ram_data_o),
    .drop_o  (dropped_o)
  );

  fwr_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .addr_o (ram_addr_o),
    .cnt_o  (word_count_o)
  );

  p_consecutive_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> (!ram_we_o || ram_addr_o == ADDR_W'($past(ram_addr_o) + ADDR_W'(1))));
  p_cnt_moves_with_we_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_o |-> $stable(word_count_o));
endmodule

// File: tb/sim_frame_word_writer.sv
module sim_frame_word_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] frame = '0;
  logic        valid = 1'b0;
  logic        fwe = 1'b0;
  logic        fval = 1'b0;
  logic        we;
  logic [9:0]  addr;
  logic [31:0] data;
  logic [15:0] cnt;
  logic        drop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  bit          m_pend = 1'b0, m_busy = 1'b0, m_drop = 1'b0;
  logic [31:0] m_hold = '0;
  logic [9:0]  m_addr = '0;
  logic [15:0] m_cnt = '0;
  bit          e_we = 1'b0;
  logic [31:0] e_data = '0;
  logic [9:0]  e_addr = '0;

  always #4 clk = ~clk;

  frame_word_writer u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .frame_valid_i(valid),
    .fmt_we_i(fwe), .fmt_i(fval), .ram_we_o(we), .ram_addr_o(addr),
    .ram_data_o(data), .word_count_o(cnt), .dropped_o(drop));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " write enable"}, 32'(we), 32'(e_we));
    if (e_we) begin
      chk({tag, " data"}, data, e_data);
      chk("R5 address", 32'(addr), 32'(e_addr));
    end
    chk("R8 word count", 32'(cnt), 32'(m_cnt));
    chk("R7 dropped flag", 32'(drop), 32'(m_drop));
  endtask

  // one cycle: check previous outputs, drive, advance model
  task automatic step(string tag, bit v, logic [95:0] f, bit w, bit fv);
    @(negedge clk);
    compare(tag);
    valid = v; frame = f; fwe = w; fval = fv;
    e_we = 1'b0;
    if (m_busy) begin
      e_we = 1'b1; e_data = m_hold; e_addr = m_addr;
      m_addr++; m_cnt++; m_busy = 1'b0;
      if (v) m_drop = 1'b1;
    end else if (v) begin
      e_we = 1'b1; e_data = f[95:64]; e_addr = m_addr;
      m_addr++; m_cnt++;
      if (m_pend) begin m_busy = 1'b1; m_hold = f[63:32]; end
    end
    if (w) m_pend = fv;
  endtask

  function automatic logic [95:0] pat(int i);
    return {32'hA500_0000 + 32'(i * 3), 32'h5B00_0000 ^ 32'(i * 7), 32'hC3C3_0000 | 32'(i)};
  endfunction

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 write enable", 32'(we), 32'd0);
    chk("R1 count", 32'(cnt), 32'd0);
    chk("R1 dropped", 32'(drop), 32'd0);
    // R2 one-word format, spaced frames
    for (int i = 0; i < 16; i++) begin
      step("R2", 1'b1, pat(i), 1'b0, 1'b0);
      step("R2", 1'b0, '1, 1'b0, 1'b0);
    end
    // R9 back-to-back one-word frames
    for (int i = 16; i < 40; i++) step("R9", 1'b1, pat(i), 1'b0, 1'b0);
    step("R9", 1'b0, '0, 1'b1, 1'b1);
    // R3 two-word format, spaced
    for (int i = 40; i < 56; i++) begin
      step("R3", 1'b1, pat(i), 1'b0, 1'b0);
      for (int k = 0; k < (i % 3) + 1; k++) step("R3", 1'b0, '0, 1'b0, 1'b0);
    end
    // R4 bus changes after acceptance
    for (int i = 56; i < 64; i++) begin
      step("R4", 1'b1, pat(i), 1'b0, 1'b0);
      step("R4", 1'b0, ~pat(i), 1'b0, 1'b0);
    end
    // R6 format write timing
    step("R6", 1'b0, '0, 1'b1, 1'b0);
    step("R6", 1'b1, pat(70), 1'b1, 1'b1);
    step("R6", 1'b1, pat(71), 1'b0, 1'b0);
    step("R6", 1'b0, '1, 1'b1, 1'b0);
    step("R6", 1'b1, pat(72), 1'b0, 1'b0);
    step("R6", 1'b0, '0, 1'b0, 1'b0);
    step("R6", 1'b0, '0, 1'b0, 1'b0);
    // R5 address wrap with one-word frames
    for (int i = 0; i < 1100; i++) step("R5", 1'b1, pat(100 + i), 1'b0, 1'b0);
    step("R5", 1'b0, '0, 1'b1, 1'b1);
    step("R5", 1'b0, '0, 1'b0, 1'b0);
    // R7 valid during second word
    step("R7", 1'b1, pat(3000), 1'b0, 1'b0);
    step("R7", 1'b1, pat(3001), 1'b0, 1'b0);
    step("R7", 1'b0, '0, 1'b0, 1'b0);
    step("R7", 1'b1, pat(3002), 1'b0, 1'b0);
    step("R7", 1'b0, '0, 1'b0, 1'b0);
    step("R7", 1'b0, '0, 1'b0, 1'b0);
    @(negedge clk);
    compare("R7");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule